// File: doc/BRIEF.md
# Page Access Guard with Fault Status Capture

This block sits behind a page-table walker. For every translated access it receives the rights field of the leaf entry, or a fault code from the walker when no leaf was found. It decides whether the access may go ahead and returns the read, write and execute rights to install. When the access is refused it records why in a fault status register and records where in a fault address register. It then either raises an instruction-access trap or a data-access trap, or, in no-fault operation or while traps are off, lets the access through with full rights.

An access is classified by a 3-bit access index: bit 2 is a write, bit 1 is an instruction fetch and bit 0 is a supervisor access. The refusal code is computed from this index and the 3-bit rights field of the entry. Software reads the two registers through a small read port. A read of the status register empties it.

The recorder is a three-state machine. REC_EMPTY means no fault is held. REC_HELD means one unread fault is held. REC_OVERRUN means a fault arrived while an earlier one was still unread. The transitions are:
- A fault moves REC_EMPTY to REC_HELD.
- A fault moves REC_HELD or REC_OVERRUN to REC_OVERRUN.
- A status read with no fault in the same cycle moves REC_HELD or REC_OVERRUN back to REC_EMPTY.
- A status read together with a fault lands in REC_HELD.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index is {write, fetch, supervisor}. For a user access to rights code 6 or 7 the fault type is 3 (privilege). Otherwise the fault type is 2 (protection) when the accessor's own rights for that code lack one that the access needs: read for a plain load, write for a write, execute for a fetch, and both write and execute when both bits are set. Otherwise the fault type is 0 (allowed).
- R2: Supervisor rights as {r,w,x} by code 0..7 are: 100, 110, 101, 111, 001, 110, 101, 111. User rights are: 100, 110, 101, 111, 001, 100, 000, 000. An allowed access returns the accessor's rights.
- R3: With no-fault mode on, a table fault of a user access is dropped. No record is made, no trap is raised, and the table rights are returned.
- R4: A fault loads the status register with the walk level in bits 9:8, the access index in bits 7:5, the fault type in bits 4:2, and 1 in bit 1 (valid).
- R5: A fault that arrives while the status register is nonzero, and is not being read, sets bit 0 (overrun). Only the newest fault's fields are kept.
- R6: A fault loads the fault address register with the request address, with its low PAGE_BITS bits cleared.
- R7: A fault while no-fault mode is on or traps are off raises no trap, returns rights 111, and is still recorded.
- R8: Any other fault returns rights 000 and raises exactly one trap: the instruction trap for a fetch, the data trap otherwise.
- R9: Read select 0 returns the status register and empties it after that cycle. Read select 1 returns the fault address register and leaves it unchanged.
- R10: A fault in the same cycle as a status read wins. The read returns the old value, and the register then holds the new fault with bit 0 clear.
- R11: A nonzero walk fault type is recorded with its level. It overrides the table, and no-fault mode never drops it.
- R12: After reset both registers read 0 and no response or trap is driven.
- R13: Response, rights and traps are registered and appear in the cycle after the request. The response is low in a cycle after no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is from supervisor mode |
| req_acc | input | 3 | Rights field of the leaf entry |
| req_va | input | ADDR_W | Virtual address of the access |
| walk_level | input | 2 | Level at which the walk failed |
| walk_type | input | 3 | Walk fault type, 0 = walk succeeded |
| nf_mode | input | 1 | No-fault mode |
| traps_en | input | 1 | Traps enabled |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 = fault status, 1 = fault address |
| resp_valid | output | 1 | Result of last cycle's request |
| perm_r | output | 1 | Read right granted |
| perm_w | output | 1 | Write right granted |
| perm_x | output | 1 | Execute right granted |
| trap_ifault | output | 1 | Instruction-access trap |
| trap_dfault | output | 1 | Data-access trap |
| rd_data | output | ADDR_W | Selected register contents |

## Verification
Fault capture and clear-on-read can fall in the same cycle. When they do, the overrun decision and the final register contents depend on which one wins. The bench first leaves a fault unread. It then issues a faulting request in the same cycle as a status read. It checks that the read returns the old record, and that a later read shows only the new fault with the overrun bit clear. A sweep over all 64 index and rights pairs also piles up unread faults, which judges the overrun path against a scoreboard model.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;

    localparam int unsigned IDX_W = 3;
    localparam int unsigned ACC_W = 3;
    localparam int unsigned FT_W  = 3;
    localparam int unsigned LVL_W = 2;
    // status layout: overrun, valid, type, index, level
    localparam int unsigned STAT_W = 2 + FT_W + IDX_W + LVL_W;

    localparam logic [FT_W-1:0] FT_NONE = 3'd0;
    localparam logic [FT_W-1:0] FT_PROT = 3'd2;
    localparam logic [FT_W-1:0] FT_PRIV = 3'd3;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] idx;
        logic [FT_W-1:0]  ftype;
    } fault_rec_t;

    typedef enum logic [1:0] {
        REC_EMPTY   = 2'd0,
        REC_HELD    = 2'd1,
        REC_OVERRUN = 2'd2
    } rec_state_t;

endpackage

// File: rtl/mmu_rights_table.sv
module mmu_rights_table
    import mmu_guard_pkg::*;
(
    input  logic             user,
    input  logic [ACC_W-1:0] acc,
    output rights_t          grant
);
    always_comb begin
        grant = '0;
        unique case (acc)
            3'd0: grant = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
            3'd1: grant = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
            3'd2: grant = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            3'd3: grant = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            3'd4: grant = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
            3'd5: grant = user ? '{rd: 1'b1, wr: 1'b0, ex: 1'b0}
                               : '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
            3'd6: grant = user ? '{rd: 1'b0, wr: 1'b0, ex: 1'b0}
                               : '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            3'd7: grant = user ? '{rd: 1'b0, wr: 1'b0, ex: 1'b0}
                               : '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            default: grant = '0;
        endcase
    end
endmodule

// File: rtl/mmu_rights_check.sv
module mmu_rights_check
    import mmu_guard_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [ACC_W-1:0] acc,
    output rights_t          grant,
    output logic [FT_W-1:0]  ftype
);
    logic is_user;
    logic need_rd, need_wr, need_ex;
    logic lacking;

    assign is_user = ~idx[0];

    mmu_rights_table u_table (
        .user  (is_user),
        .acc   (acc),
        .grant (grant)
    );

    // a write needs W, a fetch needs X, a plain load needs R
    assign need_wr = idx[2];
    assign need_ex = idx[1];
    assign need_rd = ~idx[2] & ~idx[1];

    assign lacking = (need_rd & ~grant.rd) |
                     (need_wr & ~grant.wr) |
                     (need_ex & ~grant.ex);

    always_comb begin
        if (is_user && acc[2] && acc[1]) begin
            ftype = FT_PRIV;
        end else if (lacking) begin
            ftype = FT_PROT;
        end else begin
            ftype = FT_NONE;
        end
    end
endmodule

// File: rtl/mmu_fault_rec.sv
module mmu_fault_rec
    import mmu_guard_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_evt,
    input  fault_rec_t        fault_info,
    input  logic [ADDR_W-1:0] fault_va,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [ADDR_W-1:0] rd_data
);
    localparam int unsigned PAD_W = ADDR_W - STAT_W;
    localparam logic [ADDR_W-1:0] PAGE_MASK =
        {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    rec_state_t        st, st_nx;
    fault_rec_t        body;
    logic [ADDR_W-1:0] far_q;
    logic              stat_clr;
    logic [ADDR_W-1:0] fsr_view;

    assign stat_clr = rd_en & ~rd_sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= REC_EMPTY;
        end else begin
            st <= st_nx;
        end
    end

    // transitions: a fault wins over a clearing read
    always_comb begin
        st_nx = st;
        unique case (st)
            REC_EMPTY: begin
                if (fault_evt) st_nx = REC_HELD;
            end
            REC_HELD, REC_OVERRUN: begin
                if (fault_evt) begin
                    st_nx = stat_clr ? REC_HELD : REC_OVERRUN;
                end else if (stat_clr) begin
                    st_nx = REC_EMPTY;
                end
            end
            default: st_nx = REC_EMPTY;
        endcase
    end

    // record contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body  <= '0;
            far_q <= '0;
        end else begin
            if (fault_evt) begin
                body  <= fault_info;
                far_q <= fault_va & PAGE_MASK;
            end else if (stat_clr) begin
                body  <= '0;
            end
        end
    end

    assign fsr_view = {{PAD_W{1'b0}}, body,
                       (st != REC_EMPTY), (st == REC_OVERRUN)};

    assign rd_data = rd_sel ? far_q : fsr_view;

    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == REC_OVERRUN && !stat_clr) |=> (st == REC_OVERRUN)); // R5

    AST_FAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_evt |=> $stable(far_q)); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !fault_evt) |=> (fsr_view == '0)); // R9

    AST_FRESH_ON_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && fault_evt) |=> (st == REC_HELD)); // R10

endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
    import mmu_guard_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_super,
    input  logic [ACC_W-1:0]  req_acc,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [LVL_W-1:0]  walk_level,
    input  logic [FT_W-1:0]   walk_type,
    input  logic              nf_mode,
    input  logic              traps_en,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic              resp_valid,
    output logic              perm_r,
    output logic              perm_w,
    output logic              perm_x,
    output logic              trap_ifault,
    output logic              trap_dfault,
    output logic [ADDR_W-1:0] rd_data
);
    logic [IDX_W-1:0] idx;
    rights_t          tbl_grant;
    logic [FT_W-1:0]  tbl_type;
    logic             walk_fail;
    logic             nf_drop;
    logic [FT_W-1:0]  eff_type;
    logic             fault_evt;
    logic             quiet;
    fault_rec_t       info;
    rights_t          grant_nx;
    logic             ti_nx, td_nx;

    assign idx = {req_write, req_fetch, req_super};

    mmu_rights_check u_check (
        .idx   (idx),
        .acc   (req_acc),
        .grant (tbl_grant),
        .ftype (tbl_type)
    );

    assign walk_fail = (walk_type != FT_NONE);
    assign nf_drop   = nf_mode & ~req_super;
    assign quiet     = nf_mode | ~traps_en;

    always_comb begin
        if (walk_fail) begin
            eff_type = walk_type;
        end else if (nf_drop) begin
            eff_type = FT_NONE;
        end else begin
            eff_type = tbl_type;
        end
    end

    assign fault_evt = req_valid & (eff_type != FT_NONE);

    assign info.lvl   = walk_fail ? walk_level : '0;
    assign info.idx   = idx;
    assign info.ftype = eff_type;

    always_comb begin
        grant_nx = tbl_grant;
        ti_nx    = 1'b0;
        td_nx    = 1'b0;
        if (eff_type != FT_NONE) begin
            if (quiet) begin
                grant_nx = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            end else begin
                grant_nx = '0;
                ti_nx    = req_fetch;
                td_nx    = ~req_fetch;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            perm_r      <= 1'b0;
            perm_w      <= 1'b0;
            perm_x      <= 1'b0;
            trap_ifault <= 1'b0;
            trap_dfault <= 1'b0;
        end else begin
            resp_valid  <= req_valid;
            perm_r      <= req_valid & grant_nx.rd;
            perm_w      <= req_valid & grant_nx.wr;
            perm_x      <= req_valid & grant_nx.ex;
            trap_ifault <= req_valid & ti_nx;
            trap_dfault <= req_valid & td_nx;
        end
    end

    mmu_fault_rec #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_evt  (fault_evt),
        .fault_info (info),
        .fault_va   (req_va),
        .rd_en      (rd_en),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data)
    );

    AST_ONE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_ifault && trap_dfault)); // R8

    AST_TRAP_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ifault || trap_dfault) |-> !(perm_r || perm_w || perm_x)); // R8

    AST_QUIET_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (nf_mode || !traps_en)) |=> !(trap_ifault || trap_dfault)); // R7

    AST_LOAD_NO_ITRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fetch) |=> !trap_ifault); // R8

    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R13

    AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R13

endmodule

// File: tb/mmu_access_guard_test.sv
`timescale 1ns/1ps
module mmu_access_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_fetch = 0, req_super = 0;
    logic [2:0]  req_acc = 0;
    logic [31:0] req_va = 0;
    logic [1:0]  walk_level = 0;
    logic [2:0]  walk_type = 0;
    logic        nf_mode = 0, traps_en = 1;
    logic        rd_en = 0, rd_sel = 0;
    logic        resp_valid, perm_r, perm_w, perm_x, trap_ifault, trap_dfault;
    logic [31:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [4:0]  expq[$];
    logic [31:0] m_fsr = 0;
    logic [31:0] m_far = 0;

    always #2 clk = ~clk;

    mmu_access_guard uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_fetch(req_fetch), .req_super(req_super), .req_acc(req_acc),
        .req_va(req_va), .walk_level(walk_level), .walk_type(walk_type),
        .nf_mode(nf_mode), .traps_en(traps_en), .rd_en(rd_en), .rd_sel(rd_sel),
        .resp_valid(resp_valid), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
        .trap_ifault(trap_ifault), .trap_dfault(trap_dfault), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R2 rights tables as {r,w,x}
    function automatic logic [2:0] b_rights(input logic user, input logic [2:0] acc);
        case (acc)
            3'd0: return 3'b100;
            3'd1: return 3'b110;
            3'd2: return 3'b101;
            3'd3: return 3'b111;
            3'd4: return 3'b001;
            3'd5: return user ? 3'b100 : 3'b110;
            3'd6: return user ? 3'b000 : 3'b101;
            default: return user ? 3'b000 : 3'b111;
        endcase
    endfunction

    // R1 fault type of the table
    function automatic logic [2:0] b_type(input logic w, input logic f,
                                          input logic s, input logic [2:0] acc);
        logic [2:0] r;
        r = b_rights(!s, acc);
        if (!s && acc >= 3'd6) return 3'd3;
        if ((w && !r[1]) || (f && !r[0]) || (!w && !f && !r[2])) return 3'd2;
        return 3'd0;
    endfunction

    task automatic drive(input logic v, input logic w, input logic f, input logic s,
                         input logic [2:0] acc, input logic [31:0] va,
                         input logic [1:0] lvl, input logic [2:0] wt,
                         input logic nf, input logic te,
                         input logic rd, input logic sel, input string tag);
        logic [2:0]  ft;
        logic        flt, quiet, clr;
        logic [2:0]  pe;
        logic [31:0] rec;
        @(negedge clk);
        req_valid = v; req_write = w; req_fetch = f; req_super = s;
        req_acc = acc; req_va = va; walk_level = lvl; walk_type = wt;
        nf_mode = nf; traps_en = te; rd_en = rd; rd_sel = sel;
        if (rd) begin
            #0.5;
            chk(rd_data === (sel ? m_far : m_fsr), tag, rd_data, sel ? m_far : m_fsr);
        end
        // R11 walk faults override and are never dropped; R3 drop of user table faults
        if (wt != 3'd0) ft = wt;
        else if (nf && !s) ft = 3'd0;
        else ft = b_type(w, f, s, acc);
        flt   = v && (ft != 3'd0);
        quiet = nf || !te;
        clr   = rd && !sel;
        rec   = {22'd0, (wt != 3'd0) ? lvl : 2'd0, w, f, s, ft, 1'b1, 1'b0};
        if (flt) begin
            m_fsr = (m_fsr != 0 && !clr) ? (rec | 32'd1) : rec;   // R5 R10
            m_far = {va[31:12], 12'd0};                           // R6
        end else if (clr) begin
            m_fsr = 0;                                             // R9
        end
        if (v) begin
            if (!flt) pe = b_rights(!s, acc);
            else if (quiet) pe = 3'b111;                           // R7
            else pe = 3'b000;                                      // R8
            expq.push_back({pe, flt && !quiet && f, flt && !quiet && !f});
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; rd_en = 0; walk_type = 0;
    endtask

    // scoreboard monitor, R13 timing
    initial begin
        logic [4:0] e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && resp_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R13 unexpected response", 32'd1, 32'd0);
                end else begin
                    e = expq.pop_front();
                    chk({perm_r, perm_w, perm_x, trap_ifault, trap_dfault} === e,
                        "R1 R2 R8 R13 response",
                        {27'd0, perm_r, perm_w, perm_x, trap_ifault, trap_dfault},
                        {27'd0, e});
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R13 watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!resp_valid && !trap_ifault && !trap_dfault, "R12 outputs after reset",
            {30'd0, trap_ifault, resp_valid}, 32'd0);
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R12 status after reset");
        drive(0,0,0,0,0,0,0,0, 0,1, 1,1, "R12 address after reset");
        idle();

        // R4 R6 single user write to read-only page, unaligned address
        drive(1,1,0,0,3'd0,32'hABCD_E123,0,0, 0,1, 0,0, "R4");
        idle();
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R4 status fields");
        drive(0,0,0,0,0,0,0,0, 0,1, 1,1, "R6 aligned address");
        drive(0,0,0,0,0,0,0,0, 0,1, 1,1, "R9 address read keeps value");
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R9 status cleared by read");
        idle();

        // R1 R2 R8 full sweep of index and rights, faults pile up
        for (int a = 0; a < 8; a++) begin
            for (int i = 0; i < 8; i++) begin
                drive(1, i[2], i[1], i[0], a[2:0], {a[7:0], i[7:0], 16'h5A5A},
                      0,0, 0,1, 0,0, "R1");
            end
        end
        idle();
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R5 overrun after sweep");
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R9 empty after read");

        // R5 two faults: supervisor fetch from code 0 then user load code 6
        drive(1,0,1,1,3'd0,32'h1000_0000,0,0, 0,1, 0,0, "R5");
        drive(1,0,0,0,3'd6,32'h2000_0fff,0,0, 0,1, 0,0, "R5");
        idle();
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R5 newest fields with overrun");

        // R3 no-fault user: privilege fault dropped, table rights returned
        drive(1,0,0,0,3'd7,32'h3000_0000,0,0, 1,1, 0,0, "R3");
        drive(1,1,0,0,3'd0,32'h3100_0000,0,0, 1,1, 0,0, "R3");
        idle();
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R3 nothing recorded");

        // R7 supervisor fault in no-fault mode, then with traps off
        drive(1,1,0,1,3'd0,32'h4000_0000,0,0, 1,1, 0,0, "R7");
        idle();
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R7 recorded under no-fault");
        drive(1,0,1,0,3'd1,32'h4400_0000,0,0, 0,0, 0,0, "R7");
        idle();
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R7 recorded with traps off");

        // R11 walk fault: user in no-fault mode still recorded, then trapping load
        drive(1,0,0,0,3'd7,32'h5000_0000,2'd2,3'd1, 1,1, 0,0, "R11");
        idle();
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R11 walk record level 2");
        drive(1,0,0,1,3'd3,32'h5500_0000,2'd3,3'd4, 0,1, 0,0, "R11");
        idle();

        // R10 status holds a fault, new fault arrives with a status read
        drive(1,0,1,0,3'd1,32'h6600_0000,0,0, 0,1, 1,0, "R10 read returns old");
        idle();
        drive(0,0,0,0,0,0,0,0, 0,1, 1,0, "R10 fresh record no overrun");
        drive(0,0,0,0,0,0,0,0, 0,1, 1,1, "R10 address of new fault");
        idle();
        idle();

        chk(expq.size() == 0, "R13 all responses seen", expq.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule